// File: doc/BRIEF.md
# Dual-Pixel Stream Decimator

This block reduces a video stream to half its width and half its height. The source delivers two horizontally adjacent 24-bit RGB pixels on every cycle of a clock that runs at half the pixel rate. The first pixel of the pair is called even and the second is called odd. The block keeps one pixel of each pair and only the lines that have an even index. It needs no filter arithmetic: the downsampling comes from the paired input format.

The output stays in the half-rate clock domain and carries one pixel per clock. Three markers go with it: pixel valid, line start and frame start. A downstream stage, such as a display-panel formatter, can consume the reduced image at the same clock as the video receiver, with no clock crossing.

Line indices count data-enable bursts from the most recent vertical sync. Line 0 is the first burst after that sync. A parameter selects which pixel of the pair survives, and the default keeps the even one.

Top module: `pair_decimator`

## Requirements
- R1: While `rst_n` is low, `valid_o`, `line_start_o` and `frame_start_o` are 0, whatever the other inputs do.
- R2: On a kept line, `valid_o` is high in the cycle after each cycle with `de_i` high, and low otherwise.
- R3: With the default `KEEP_FIRST = 1`, every valid output pixel equals the `pix_even_i` value sampled one cycle earlier. The odd pixel never appears on the output.
- R4: A line is a run of consecutive `de_i`-high cycles. A line whose index since the last vertical sync is odd produces no valid output.
- R5: A cycle with `vsync_i` high resets the line index to 0. The first line after a vertical sync is therefore kept, even when the previous frame ended on an odd line count.
- R6: `line_start_o` is a one-cycle pulse that coincides with the first valid pixel of each kept line. It never occurs on dropped lines.
- R7: `frame_start_o` pulses exactly once per frame, together with the first valid pixel after a vertical sync. Later lines of the same frame do not raise it.
- R8: The number of valid output pixels for a kept line equals the number of input cycles in that line, which is half the active input pixel count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_i | input | 1 | Vertical sync; high for one or more cycles between frames |
| de_i | input | 1 | Input data enable; high during active pixel pairs |
| pix_even_i | input | PIX_W | First (even) pixel of the pair, RGB |
| pix_odd_i | input | PIX_W | Second (odd) pixel of the pair, RGB |
| pix_o | output | PIX_W | Surviving pixel |
| valid_o | output | 1 | Output pixel valid |
| line_start_o | output | 1 | First pixel of a kept line |
| frame_start_o | output | 1 | First pixel of a frame |

## Verification
Every output of this block comes from exactly one register stage. Pixel, valid, line-start and frame-start for an input cycle are therefore all due on the clock edge that follows the edge at which that cycle was sampled.

The driver applies each input cycle at the falling edge. It pushes the expected marker set and pixel for that cycle into a queue. The monitor pops one entry just after the next rising edge and compares it field by field.

A per-line count of valid outputs is compared two idle cycles after each line ends. This leaves room for the one-stage lag. Frames with odd line counts and one-pixel lines cover the line-index reset and the case where line start and frame start fall on the same cycle.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

  // Markers that travel with every output pixel.
  typedef struct packed {
    logic valid;
    logic line_start;
    logic frame_start;
  } pdec_mark_t;

  // A line survives when its index since vertical sync is even.
  function automatic logic line_is_kept(input logic idx_lsb);
    return ~idx_lsb;
  endfunction

  // Rising edge of data enable marks the first cycle of a line.
  function automatic logic burst_begins(input logic de_now, input logic de_prev);
    return de_now & ~de_prev;
  endfunction

  // Falling edge of data enable marks the end of a line.
  function automatic logic burst_ends(input logic de_now, input logic de_prev);
    return ~de_now & de_prev;
  endfunction

endpackage

// File: rtl/pdec_line_track.sv
module pdec_line_track
  import pdec_pkg::*;
#(
  parameter int LINE_W = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vsync_i,
  input  logic de_i,
  output logic keep_line,
  output logic kept_de,
  output logic line_first,
  output logic frame_first
);

  logic              de_q;
  logic [LINE_W-1:0] line_idx;
  logic              frame_pend;
  logic              begin_ev;
  logic              end_ev;

  assign begin_ev    = burst_begins(de_i, de_q);
  assign end_ev      = burst_ends(de_i, de_q);
  assign keep_line   = line_is_kept(line_idx[0]);
  assign kept_de     = de_i & keep_line & ~vsync_i;
  assign line_first  = kept_de & begin_ev;
  assign frame_first = line_first & frame_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q       <= 1'b0;
      line_idx   <= '0;
      frame_pend <= 1'b0;
    end else begin
      de_q <= de_i;
      if (vsync_i) begin
        line_idx   <= '0;
        frame_pend <= 1'b1;
      end else begin
        if (end_ev)  line_idx   <= line_idx + 1'b1;
        if (kept_de) frame_pend <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pdec_pix_sel.sv
module pdec_pix_sel #(
  parameter int PIX_W      = 24,
  parameter bit KEEP_FIRST = 1'b1
) (
  input  logic [PIX_W-1:0] pix_even_i,
  input  logic [PIX_W-1:0] pix_odd_i,
  output logic [PIX_W-1:0] pix_sel_o
);

  generate
    if (KEEP_FIRST) begin : g_first
      assign pix_sel_o = pix_even_i;
      logic unused_odd;
      assign unused_odd = ^pix_odd_i;
    end else begin : g_second
      assign pix_sel_o = pix_odd_i;
      logic unused_even;
      assign unused_even = ^pix_even_i;
    end
  endgenerate

endmodule

// File: rtl/pdec_out_stage.sv
module pdec_out_stage
  import pdec_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kept_de,
  input  logic             line_first,
  input  logic             frame_first,
  input  logic [PIX_W-1:0] pix_sel,
  output logic [PIX_W-1:0] pix_o,
  output pdec_mark_t       mark_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_o  <= '0;
      mark_o <= '0;
    end else begin
      mark_o.valid       <= kept_de;
      mark_o.line_start  <= line_first;
      mark_o.frame_start <= frame_first;
      if (kept_de) pix_o <= pix_sel;
    end
  end

endmodule

// File: rtl/pair_decimator.sv
module pair_decimator
  import pdec_pkg::*;
#(
  parameter int PIX_W      = 24,
  parameter int LINE_W     = 11,
  parameter bit KEEP_FIRST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vsync_i,
  input  logic             de_i,
  input  logic [PIX_W-1:0] pix_even_i,
  input  logic [PIX_W-1:0] pix_odd_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             valid_o,
  output logic             line_start_o,
  output logic             frame_start_o
);

  logic             keep_line;
  logic             kept_de;
  logic             line_first;
  logic             frame_first;
  logic [PIX_W-1:0] pix_sel;
  pdec_mark_t       mark;

  pdec_line_track #(.LINE_W(LINE_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .vsync_i     (vsync_i),
    .de_i        (de_i),
    .keep_line   (keep_line),
    .kept_de     (kept_de),
    .line_first  (line_first),
    .frame_first (frame_first)
  );

  pdec_pix_sel #(.PIX_W(PIX_W), .KEEP_FIRST(KEEP_FIRST)) u_sel (
    .pix_even_i (pix_even_i),
    .pix_odd_i  (pix_odd_i),
    .pix_sel_o  (pix_sel)
  );

  pdec_out_stage #(.PIX_W(PIX_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .kept_de     (kept_de),
    .line_first  (line_first),
    .frame_first (frame_first),
    .pix_sel     (pix_sel),
    .pix_o       (pix_o),
    .mark_o      (mark)
  );

  assign valid_o       = mark.valid;
  assign line_start_o  = mark.line_start;
  assign frame_start_o = mark.frame_start;

endmodule

// File: rtl/pdec_checker.sv
module pdec_checker #(
  parameter int PIX_W      = 24,
  parameter bit KEEP_FIRST = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vsync_i,
  input logic             de_i,
  input logic [PIX_W-1:0] pix_even_i,
  input logic [PIX_W-1:0] pix_odd_i,
  input logic [PIX_W-1:0] pix_o,
  input logic             valid_o,
  input logic             line_start_o,
  input logic             frame_start_o,
  input logic             keep_line
);

  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r1: assert (!valid_o && !line_start_o && !frame_start_o);
    end
  end

  p_valid_needs_de_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(de_i));

  p_kept_pixel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> pix_o == (KEEP_FIRST ? $past(pix_even_i) : $past(pix_odd_i)));

  p_drop_odd_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (de_i && !keep_line) |=> !valid_o);

  p_sync_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_i |=> keep_line);

  p_line_start_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_start_o |-> valid_o && !$past(de_i, 2));

  p_frame_in_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> line_start_o);

endmodule

bind pair_decimator pdec_checker #(.PIX_W(PIX_W), .KEEP_FIRST(KEEP_FIRST)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .vsync_i       (vsync_i),
  .de_i          (de_i),
  .pix_even_i    (pix_even_i),
  .pix_odd_i     (pix_odd_i),
  .pix_o         (pix_o),
  .valid_o       (valid_o),
  .line_start_o  (line_start_o),
  .frame_start_o (frame_start_o),
  .keep_line     (keep_line)
);

// File: tb/pair_decimator_test.sv
module pair_decimator_test;

  localparam int PW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          vsync_i = 1'b0;
  logic          de_i = 1'b0;
  logic [PW-1:0] pix_even_i = '0;
  logic [PW-1:0] pix_odd_i = '0;
  logic [PW-1:0] pix_o;
  logic          valid_o, line_start_o, frame_start_o;

  pair_decimator uut (
    .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .de_i(de_i),
    .pix_even_i(pix_even_i), .pix_odd_i(pix_odd_i), .pix_o(pix_o),
    .valid_o(valid_o), .line_start_o(line_start_o), .frame_start_o(frame_start_o)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic          v;
    logic          ls;
    logic          fs;
    logic [PW-1:0] px;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   vcount = 0;
  bit   mon_on = 1'b0;

  // Reference state, restated from the requirements.
  int   m_line = 0;
  bit   m_pend = 1'b0;
  bit   m_prevde = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive_cycle(input bit vs, input bit de, input logic [PW-1:0] ev);
    exp_t e;
    bit kept;
    @(negedge clk);
    vsync_i    = vs;
    de_i       = de;
    pix_even_i = ev;
    pix_odd_i  = ~ev;
    kept = de && !vs && (m_line % 2 == 0);
    e.v  = kept;
    e.ls = kept && !m_prevde;
    e.fs = kept && !m_prevde && m_pend;
    e.px = ev;
    q.push_back(e);
    if (vs) begin
      m_line = 0;
      m_pend = 1'b1;
    end else begin
      if (m_prevde && !de) m_line++;
      if (kept) m_pend = 1'b0;
    end
    m_prevde = de;
  endtask

  task automatic send_vsync(input int n);
    for (int i = 0; i < n; i++) drive_cycle(1'b1, 1'b0, '0);
    drive_cycle(1'b0, 1'b0, '0);
  endtask

  task automatic send_line(input int frame, input int len);
    int expn;
    expn = (m_line % 2 == 0) ? len : 0;
    vcount = 0;
    for (int i = 0; i < len; i++)
      drive_cycle(1'b0, 1'b1, {8'(frame), 8'(m_line), 8'(2 * i)});
    drive_cycle(1'b0, 1'b0, '0);
    drive_cycle(1'b0, 1'b0, '0);
    // R8 valid count per kept line; R4 zero on odd lines
    check(vcount == expn, (expn == 0) ? "R4 dropped-line count" : "R8 kept-line count",
          vcount, expn);
  endtask

  always @(posedge clk) begin
    exp_t e;
    #1;
    if (mon_on && q.size() > 0) begin
      e = q.pop_front();
      if (valid_o) vcount++;
      check(valid_o == e.v, "R2 valid", int'(valid_o), int'(e.v));
      check(line_start_o == e.ls, "R6 line_start", int'(line_start_o), int'(e.ls));
      check(frame_start_o == e.fs, "R7 frame_start", int'(frame_start_o), int'(e.fs));
      if (e.v) check(pix_o == e.px, "R3 even pixel", int'(pix_o), int'(e.px));
    end
  end

  initial begin
    #(200000 * 20);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: activity on the inputs while reset is held
    de_i = 1'b1;
    vsync_i = 1'b0;
    pix_even_i = 24'hABCDEF;
    repeat (4) @(negedge clk);
    check(!valid_o && !line_start_o && !frame_start_o, "R1 reset outputs",
          {valid_o, line_start_o, frame_start_o}, 0);
    de_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // Frame 1: five lines of eight pairs
    send_vsync(2);
    for (int l = 0; l < 5; l++) send_line(1, 8);
    // Frame 2: three lines, so the index ends odd
    send_vsync(1);
    for (int l = 0; l < 3; l++) send_line(2, 6);
    // Frame 3: R5, line 0 is kept after the sync; one-pair lines
    send_vsync(3);
    for (int l = 0; l < 4; l++) send_line(3, 1);
    // Frame 4: varied lengths
    send_vsync(1);
    send_line(4, 3);
    send_line(4, 5);
    send_line(4, 2);
    repeat (3) drive_cycle(1'b0, 1'b0, '0);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule